// File: doc/BRIEF.md
# Multichannel Sample Frame Multiplexer

This block gathers the most recent digitized feedback sample of each of several power-stage channels and turns them into an unbroken stream of fixed-length frames. The frames go to a downstream 8B/10B encoder that drives a single isolating pulse transformer. Each output symbol is an 8-bit value with a flag that marks it as a control symbol or a data symbol.

A frame opens with a control header and carries one data symbol per channel. The channel is identified only by its position after the header. There are no address bits and no terminating symbol. All channel samples are copied into a shadow set on the same clock edge that presents the header, so the frame reflects one instant even if the inputs change while the frame is being sent. An on/off command request is delivered by swapping the ordinary header of the next frame for a command header, and the request is acknowledged while that header is on the output. While the block is disabled it sends back-to-back idle symbols, so the line keeps toggling.

Symbols leave through a valid/ready handshake. Valid stays high from the first cycle after reset onward. When ready is low the symbol and all sequencing state hold. Changes to the enable input only take effect at frame boundaries.

Top module: `sample_frame_mux`

## Requirements
- R1: While `rst_n` is low, `sym_valid` is 0. In the first cycle after reset is released, the output is `sym_valid`=1 with the idle symbol 0x3C and `sym_ctrl`=1.
- R2: While `enable` is low at a frame boundary, every symbol presented is the idle symbol 0x3C with `sym_ctrl`=1, back to back.
- R3: A frame is a header followed by exactly NUM_CH data symbols with `sym_ctrl`=0. The ordinary header is 0x BC with `sym_ctrl`=1. Channel 1 (bits [7:0] of `sample_in`) comes first, and channel c uses bits [8c-1:8c-8].
- R4: While `enable` stays high, the next header follows the last data symbol directly. No idle symbol and no stop symbol appear between frames.
- R5: The data symbols of a frame equal `sample_in` as it was on the clock edge that put that frame's header on the output. Changes to `sample_in` later in the frame have no effect on that frame.
- R6: After a `cmd_req` pulse, the next header is 0xFC if `cmd_on` was 1, or 0x7C if it was 0. `cmd_ack` is high for exactly the cycle in which that command header is first presented. The following header is 0xBC again unless another request arrived.
- R7: While `sym_valid`=1 and `out_ready`=0, `sym_data`, `sym_ctrl` and the position in the frame do not change.
- R8: When `enable` falls in the middle of a frame, the remaining data symbols of that frame are still sent before idle symbols start.
- R9: If several requests arrive before a header, the latest `cmd_on` value decides the command. A request on the same edge that presents a header is kept for the following header.
- R10: Once `sym_valid` has risen after reset, it never falls until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Send frames (1) or idle symbols (0), sampled at frame boundaries |
| sample_in | input | NUM_CH*8 | Latest sample of each channel, channel 1 in the low byte |
| cmd_req | input | 1 | One-cycle request to send an on/off command |
| cmd_on | input | 1 | Command polarity captured with `cmd_req`: 1 on, 0 off |
| out_ready | input | 1 | Encoder accepts the presented symbol this cycle |
| sym_valid | output | 1 | A symbol is presented |
| sym_data | output | 8 | Symbol value |
| sym_ctrl | output | 1 | 1 for a control symbol, 0 for a data symbol |
| cmd_ack | output | 1 | Command header presented this cycle |

## Verification
The hardest case to reach from the ports is a command request that lands on the exact edge where a header is loaded. The block must neither consume that request nor lose it. The bench lines up a `cmd_req` pulse with the negative edge at which the last data symbol of a frame is shown. It then expects the ordinary header first and the command header one frame later. Two further cases are also driven deliberately: a stall held across several cycles in the middle of a frame, and a disable that arrives partway through a frame.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int SYM_W = 8;

  // control symbol values (8B/10B K-character byte values)
  localparam logic [SYM_W-1:0] SYM_IDLE    = 8'h3C;
  localparam logic [SYM_W-1:0] SYM_HDR     = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_HDR_ON  = 8'hFC;
  localparam logic [SYM_W-1:0] SYM_HDR_OFF = 8'h7C;

  // header chosen for the next frame
  function automatic logic [SYM_W-1:0] pick_header(input logic pend, input logic on);
    if (!pend)   return SYM_HDR;
    else if (on) return SYM_HDR_ON;
    else         return SYM_HDR_OFF;
  endfunction
endpackage

// File: rtl/fm_seq.sv
module fm_seq #(
  parameter int NUM_CH = 4,
  localparam int SLOT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              enable,
  output logic              running,
  output logic [SLOT_W-1:0] slot,
  output logic              nxt_running,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic              load_evt
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CH);

  logic at_end;
  assign at_end   = !running || (slot == LAST);
  assign load_evt = adv && at_end && enable;

  always_comb begin
    nxt_running = running;
    nxt_slot    = slot;
    if (adv) begin
      if (at_end) begin
        nxt_running = enable;
        nxt_slot    = '0;
      end else begin
        nxt_slot = slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      slot    <= '0;
    end else begin
      running <= nxt_running;
      slot    <= nxt_slot;
    end
  end

  // R4
  frame_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && running && (slot == LAST) && enable |=> running && (slot == '0));

  // R8
  frame_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && running && (slot != LAST) |=> running);

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(slot) && $stable(running));
endmodule

// File: rtl/fm_shadow.sv
module fm_shadow #(
  parameter int NUM_CH = 4,
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NUM_CH*W-1:0]        sample_in,
  output logic [NUM_CH-1:0][W-1:0]   shadow
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow[c] <= '0;
      else if (load) shadow[c] <= sample_in[c*W +: W];
    end
  end

  // R5
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow));
endmodule

// File: rtl/fm_cmd.sv
module fm_cmd
  import fm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_req,
  input  logic             cmd_on,
  input  logic             consume,
  output logic [SYM_W-1:0] hdr_code,
  output logic             ack
);
  logic pend, val;

  assign hdr_code = pick_header(pend, val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      val  <= 1'b0;
      ack  <= 1'b0;
    end else begin
      ack <= consume && pend;
      if (consume) pend <= 1'b0;
      if (cmd_req) begin
        pend <= 1'b1;
        val  <= cmd_on;
      end
    end
  end

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> pend);
endmodule

// File: rtl/sample_frame_mux.sv
module sample_frame_mux
  import fm_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SLOT_W = $clog2(NUM_CH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [NUM_CH*SYM_W-1:0] sample_in,
  input  logic                    cmd_req,
  input  logic                    cmd_on,
  input  logic                    out_ready,
  output logic                    sym_valid,
  output logic [SYM_W-1:0]        sym_data,
  output logic                    sym_ctrl,
  output logic                    cmd_ack
);
  logic                          adv;
  logic                          running, nxt_running, load_evt;
  logic [SLOT_W-1:0]             slot, nxt_slot;
  logic [NUM_CH-1:0][SYM_W-1:0]  shadow;
  logic [SYM_W-1:0]              hdr_code;
  logic [SYM_W-1:0]              nxt_data;
  logic                          nxt_ctrl;

  assign adv = sym_valid && out_ready;

  fm_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .enable(enable),
    .running(running), .slot(slot),
    .nxt_running(nxt_running), .nxt_slot(nxt_slot), .load_evt(load_evt)
  );

  fm_shadow #(.NUM_CH(NUM_CH), .W(SYM_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .sample_in(sample_in), .shadow(shadow)
  );

  fm_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_on(cmd_on),
    .consume(load_evt), .hdr_code(hdr_code), .ack(cmd_ack)
  );

  // data slot k (1-based) carries channel k
  function automatic int chan_of(input logic [SLOT_W-1:0] s);
    return int'(s) - 1;
  endfunction

  always_comb begin
    if (!nxt_running) begin
      nxt_data = SYM_IDLE;
      nxt_ctrl = 1'b1;
    end else if (nxt_slot == '0) begin
      nxt_data = hdr_code;
      nxt_ctrl = 1'b1;
    end else begin
      nxt_data = shadow[chan_of(nxt_slot)];
      nxt_ctrl = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym_data  <= SYM_IDLE;
      sym_ctrl  <= 1'b1;
    end else begin
      sym_valid <= 1'b1;
      if (adv) begin
        sym_data <= nxt_data;
        sym_ctrl <= nxt_ctrl;
      end
    end
  end

  // R10
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> sym_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !out_ready |=> $stable(sym_data) && $stable(sym_ctrl));

  // R6
  ack_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> sym_ctrl && (sym_data == SYM_HDR_ON || sym_data == SYM_HDR_OFF));

  // R3
  data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !sym_ctrl |-> running && (slot != '0));
endmodule

// File: tb/sample_frame_mux_tb.sv
module sample_frame_mux_tb;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [NCH*8-1:0] sample_in = '0;
  logic cmd_req = 1'b0;
  logic cmd_on = 1'b0;
  logic out_ready = 1'b1;
  logic sym_valid;
  logic [7:0] sym_data;
  logic sym_ctrl;
  logic cmd_ack;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sample_frame_mux #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_in(sample_in),
    .cmd_req(cmd_req), .cmd_on(cmd_on), .out_ready(out_ready),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_ctrl(sym_ctrl),
    .cmd_ack(cmd_ack)
  );

  // {samples[31:0], header[7:0], request next, polarity}
  localparam logic [41:0] TBL [4] = '{
    {32'h44332211, 8'hBC, 1'b1, 1'b1},
    {32'h00FF807F, 8'hFC, 1'b1, 1'b0},
    {32'hA5A55A5A, 8'h7C, 1'b0, 1'b0},
    {32'h01020304, 8'hBC, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_sym(input logic [7:0] d, input logic c, input logic a, input string tag);
    checks++;
    if (sym_valid !== 1'b1 || sym_data !== d || sym_ctrl !== c || cmd_ack !== a) begin
      errors++;
      $display("FAIL %s: got v=%b d=%h c=%b ack=%b, expected v=1 d=%h c=%b ack=%b",
               tag, sym_valid, sym_data, sym_ctrl, cmd_ack, d, c, a);
    end
  endtask

  task automatic expect_frame_data(input logic [31:0] s, input string tag);
    for (int k = 0; k < NCH; k++) begin
      step();
      expect_sym(s[k*8 +: 8], 1'b0, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (sym_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got valid=%b, expected 0", sym_valid);
    end
    rst_n = 1'b1;
    step();
    expect_sym(8'h3C, 1'b1, 1'b0, "R1");
    // R2: idle while disabled
    for (int i = 0; i < 3; i++) begin
      step();
      expect_sym(8'h3C, 1'b1, 1'b0, "R2");
    end

    // table: back-to-back frames with snapshot and command headers
    enable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sample_in = TBL[i][41:10];
      step();
      // R3 R4 R6: header (command header when requested)
      expect_sym(TBL[i][9:2], 1'b1, TBL[i][9:2] != 8'hBC, "R4 header");
      // R5: change samples mid-frame
      sample_in = ~TBL[i][41:10];
      cmd_req = TBL[i][1];
      cmd_on = TBL[i][0];
      for (int k = 0; k < NCH; k++) begin
        step();
        cmd_req = 1'b0;
        expect_sym(TBL[i][10 + k*8 +: 8], 1'b0, 1'b0, "R3 R5 data");
      end
    end

    // R7: stall in mid-frame
    sample_in = 32'hCAFE0102;
    step();
    expect_sym(8'hBC, 1'b1, 1'b0, "R6 header back to ordinary");
    step();
    expect_sym(8'h02, 1'b0, 1'b0, "R7");
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      expect_sym(8'h02, 1'b0, 1'b0, "R7 stalled");
    end
    out_ready = 1'b1;
    step(); expect_sym(8'h01, 1'b0, 1'b0, "R7");
    step(); expect_sym(8'hFE, 1'b0, 1'b0, "R7");
    step(); expect_sym(8'hCA, 1'b0, 1'b0, "R7");

    // R8: disable in mid-frame
    sample_in = 32'h55667788;
    step(); expect_sym(8'hBC, 1'b1, 1'b0, "R8");
    step(); expect_sym(8'h88, 1'b0, 1'b0, "R8");
    enable = 1'b0;
    step(); expect_sym(8'h77, 1'b0, 1'b0, "R8");
    step(); expect_sym(8'h66, 1'b0, 1'b0, "R8");
    step(); expect_sym(8'h55, 1'b0, 1'b0, "R8");
    step(); expect_sym(8'h3C, 1'b1, 1'b0, "R8 idle");
    step(); expect_sym(8'h3C, 1'b1, 1'b0, "R2 idle");

    // R9: latest request wins
    cmd_req = 1'b1; cmd_on = 1'b0;
    step();
    cmd_on = 1'b1;
    step();
    cmd_req = 1'b0;
    enable = 1'b1;
    sample_in = 32'h0;
    step(); expect_sym(8'hFC, 1'b1, 1'b1, "R9 latest");
    expect_frame_data(32'h0, "R9");
    // R9: request on the header-load edge is kept for the following header
    cmd_req = 1'b1; cmd_on = 1'b0;
    sample_in = 32'h9A9B9C9D;
    step();
    cmd_req = 1'b0;
    expect_sym(8'hBC, 1'b1, 1'b0, "R9 same edge");
    expect_frame_data(32'h9A9B9C9D, "R9");
    step(); expect_sym(8'h7C, 1'b1, 1'b1, "R9 kept");
    // R10: valid held throughout
    checks++;
    if (sym_valid !== 1'b1) begin
      errors++;
      $display("FAIL R10: got valid=%b, expected 1", sym_valid);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule